// File: doc/BRIEF.md
# Board Interrupt Hub with Control Registers

This block collects sixteen external interrupt lines from a board and presents a single interrupt to the host processor. Next to the interrupt logic it keeps a small bank of general board registers for LED patterns, LED control, switch settings, miscellaneous control and status, and two card-slot control words. All of these are reached over a plain 32-bit register bus that has an address, a write strobe, write data and combinational read data.

Each input line is compared every clock with a registered copy of its own level. The registered copy follows all lines, whether or not they are enabled. When an enabled line changes, two things happen. The set/clear register is overwritten with a one-hot code that names that line. The host interrupt output then takes the line's new level. A change on a disabled line is still recorded in the level copy but causes nothing else. Software can also write the set/clear register directly. Only a fixed pattern of bits can be written in the enable and set/clear registers.

Top module: `board_irq_hub`

## Requirements
- R1: After reset every register reads zero and `host_irq` is low.
- R2: The ten storage registers (offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88, 0x90, 0xE0, 0xE4) read back the full 32-bit value last written to them.
- R3: A write to the enable register (offset 0xC0) stores the written value ANDed with 0x000FEEFF. Lines 8 and 12 can therefore never be enabled.
- R4: A write to the set/clear register (offset 0xD0) stores the written value ANDed with 0x000FEEFF.
- R5: When enabled line n has a level different from its registered copy at a clock edge, the set/clear register holds exactly bit n set after that edge.
- R6: At that same edge, `host_irq` takes the new level of line n.
- R7: A level change on a line whose enable bit is clear leaves the set/clear register and `host_irq` unchanged.
- R8: The registered level copy follows every line whether or not it is enabled. A line that changed while disabled and is enabled later produces no event until it changes again.
- R9: An address that is not one of the twelve listed offsets reads zero, and a write to it changes no register.
- R10: If several enabled lines change at the same edge, the highest-numbered one sets both the set/clear value and `host_irq`.
- R11: If an interrupt event and a bus write to offset 0xD0 fall on the same edge, the event's one-hot value is stored and the write data is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 16 | External interrupt line levels |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Write strobe, the write takes effect at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| host_irq | output | 1 | Interrupt toward the host |

## Verification
Single-line toggles on enabled lines separate the one-hot latching and the level follow-through from the path for disabled lines. The directed cases include a line that is never enableable and a line that changes while it is disabled, which shows that the level copy is kept for every line. Simultaneous changes on several enabled lines check the priority order. An event that coincides with a set/clear write checks which of the two wins. A long random mix of sparse line toggles and writes to both mapped and unmapped offsets is compared each cycle against a bench model, including read-back of a random address.

// File: rtl/board_irq_hub.sv
`timescale 1ns/1ps
module board_irq_hub #(
  parameter int N_IRQ = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] IRQ_WMASK = 32'h000FEEFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  irq_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              host_irq
);
  localparam int IDX_W = $clog2(N_IRQ);
  localparam int N_PLAIN = 10;
  localparam logic [ADDR_W-1:0] OFS_EN   = ADDR_W'(8'hC0);
  localparam logic [ADDR_W-1:0] OFS_PEND = ADDR_W'(8'hD0);
  localparam logic [ADDR_W-1:0] PLAIN_OFS [N_PLAIN] = '{
    ADDR_W'(8'h10), ADDR_W'(8'h14), ADDR_W'(8'h40), ADDR_W'(8'h60),
    ADDR_W'(8'h80), ADDR_W'(8'h84), ADDR_W'(8'h88), ADDR_W'(8'h90),
    ADDR_W'(8'hE0), ADDR_W'(8'hE4)};

  logic [DATA_W-1:0] plain_q [N_PLAIN];
  logic [DATA_W-1:0] en_q, pend_q;
  logic [N_IRQ-1:0]  lvl_q;

  logic [N_IRQ-1:0] hit;
  logic             any_hit;
  logic [IDX_W-1:0] sel;

  assign hit     = (irq_in ^ lvl_q) & en_q[N_IRQ-1:0];
  assign any_hit = |hit;

  always_comb begin
    sel = '0;
    for (int i = 0; i < N_IRQ; i++)
      if (hit[i]) sel = IDX_W'(i);
  end

  for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) plain_q[g] <= '0;
      else if (reg_we && reg_addr == PLAIN_OFS[g]) plain_q[g] <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= '0;
    else if (reg_we && reg_addr == OFS_EN) en_q <= reg_wdata & IRQ_WMASK;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_q   <= '0;
      host_irq <= 1'b0;
      lvl_q    <= '0;
    end else begin
      lvl_q <= irq_in;
      if (any_hit) begin
        pend_q   <= DATA_W'(1) << sel;
        host_irq <= irq_in[sel];
      end else if (reg_we && reg_addr == OFS_PEND) begin
        pend_q <= reg_wdata & IRQ_WMASK;
      end
    end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_EN)   reg_rdata = en_q;
    if (reg_addr == OFS_PEND) reg_rdata = pend_q;
    for (int k = 0; k < N_PLAIN; k++)
      if (reg_addr == PLAIN_OFS[k]) reg_rdata = plain_q[k];
  end
endmodule

// File: rtl/board_irq_hub_chk.sv
`timescale 1ns/1ps
module board_irq_hub_chk #(
  parameter int N_IRQ = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] IRQ_WMASK = 32'h000FEEFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_IRQ-1:0]  irq_in,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              host_irq,
  input logic [DATA_W-1:0] en_q,
  input logic [DATA_W-1:0] pend_q
);
  logic [N_IRQ-1:0] prev_in;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_in <= '0;
    else prev_in <= irq_in;

  logic ev;
  assign ev = |((irq_in ^ prev_in) & en_q[N_IRQ-1:0]);

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ev |=> $stable(host_irq));

  p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> ($countones(pend_q) == 1 && pend_q[DATA_W-1:N_IRQ] == '0));

  p_en_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(8'hC0)) |=> en_q == ($past(reg_wdata) & IRQ_WMASK));

  p_pend_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(8'hD0) && !ev) |=> pend_q == ($past(reg_wdata) & IRQ_WMASK));

  p_unaligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[1:0] != 2'b00) |-> reg_rdata == '0);
endmodule

bind board_irq_hub board_irq_hub_chk #(
  .N_IRQ(N_IRQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_WMASK(IRQ_WMASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
  .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .host_irq(host_irq), .en_q(en_q), .pend_q(pend_q)
);

// File: tb/board_irq_hub_test.sv
`timescale 1ns/1ps
module board_irq_hub_test;
  logic        clk = 0, rst_n = 0;
  logic [15:0] irq_in = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        host_irq;

  board_irq_hub uut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_irq(host_irq));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  localparam logic [31:0] WMASK = 32'h000FEEFF;

  logic [31:0] m_reg [64];
  logic [15:0] m_lvl;
  logic        m_host;

  function automatic bit mapped(input logic [7:0] a);
    case (a)
      8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88, 8'h90,
      8'hC0, 8'hD0, 8'hE0, 8'hE4: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    return mapped(a) ? m_reg[a[7:2]] : 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [15:0] in, input bit we, input logic [7:0] a, input logic [31:0] d);
    logic [15:0] hit;
    int n;
    irq_in = in; reg_we = we; reg_addr = a; reg_wdata = d;
    hit = (in ^ m_lvl) & m_reg[8'hC0 >> 2][15:0];
    n = -1;
    for (int i = 0; i < 16; i++) if (hit[i]) n = i;
    @(posedge clk); #1;
    if (n >= 0) begin
      m_reg[8'hD0 >> 2] = 32'h1 << n;
      m_host = in[n];
    end else if (we && a == 8'hD0) m_reg[8'hD0 >> 2] = d & WMASK;
    if (we && a == 8'hC0) m_reg[8'hC0 >> 2] = d & WMASK;
    else if (we && a != 8'hD0 && mapped(a)) m_reg[a[7:2]] = d;
    m_lvl = in;
    reg_we = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a);
    reg_addr = a; #1;
    check(req, reg_rdata, m_read(a));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] alist [16] = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88, 8'h90,
                               8'hC0, 8'hD0, 8'hE0, 8'hE4, 8'h00, 8'h44, 8'hD4, 8'hC2};
    logic [15:0] cur;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) m_reg[i] = '0;
    m_lvl = '0; m_host = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R1 reset state
    check("R1 host_irq", {31'h0, host_irq}, 32'h0);
    for (int k = 0; k < 12; k++) rd("R1 reset read", alist[k]);

    // R2 plain storage
    for (int k = 0; k < 12; k++)
      if (alist[k] != 8'hC0 && alist[k] != 8'hD0) tick(16'h0, 1, alist[k], 32'hA5C3_0000 ^ (32'h1111 * k));
    for (int k = 0; k < 12; k++) rd("R2 readback", alist[k]);

    // R3 / R4 masks
    tick(16'h0, 1, 8'hC0, 32'hFFFF_FFFF);
    rd("R3 enable mask", 8'hC0); check("R3 value", reg_rdata, 32'h000FEEFF);
    tick(16'h0, 1, 8'hD0, 32'hFFFF_FFFF);
    rd("R4 pend mask", 8'hD0); check("R4 value", reg_rdata, 32'h000FEEFF);

    // R9 unmapped write and read
    tick(16'h0, 1, 8'h44, 32'hDEAD_BEEF);
    rd("R9 unmapped read", 8'h44);
    for (int k = 0; k < 12; k++) rd("R9 no side effect", alist[k]);

    // R3/R7 line 8 never enableable
    tick(16'h0100, 0, 8'h00, 0);
    check("R7 line8 host", {31'h0, host_irq}, 32'h0);
    rd("R7 line8 pend", 8'hD0); check("R7 pend kept", reg_rdata, 32'h000FEEFF);

    // R5/R6 single line
    tick(16'h0108, 0, 8'h00, 0);
    rd("R5 onehot", 8'hD0); check("R5 value", reg_rdata, 32'h8);
    check("R6 host rise", {31'h0, host_irq}, 32'h1);
    tick(16'h0100, 0, 8'h00, 0);
    check("R6 host fall", {31'h0, host_irq}, 32'h0);

    // R10 simultaneous
    tick(16'h0124, 0, 8'h00, 0);
    rd("R10 priority", 8'hD0); check("R10 value", reg_rdata, 32'h20);
    check("R10 host", {31'h0, host_irq}, 32'h1);

    // R8 level kept while disabled
    tick(16'h0124, 1, 8'hC0, 32'h0);
    tick(16'h0164, 0, 8'h00, 0);
    check("R7 disabled host", {31'h0, host_irq}, 32'h1);
    rd("R7 disabled pend", 8'hD0); check("R7 pend", reg_rdata, 32'h20);
    tick(16'h0164, 1, 8'hC0, 32'h40);
    rd("R8 no event on enable", 8'hD0); check("R8 pend", reg_rdata, 32'h20);
    tick(16'h0124, 0, 8'h00, 0);
    rd("R8 later event", 8'hD0); check("R8 pend2", reg_rdata, 32'h40);
    check("R8 host", {31'h0, host_irq}, 32'h0);

    // R11 event beats bus write
    tick(16'h0124, 1, 8'hC0, 32'h2);
    tick(16'h0126, 1, 8'hD0, 32'h000F_FFFF);
    rd("R11 collision", 8'hD0); check("R11 value", reg_rdata, 32'h2);
    check("R11 host", {31'h0, host_irq}, 32'h1);

    // random mix: R2 R4 R5 R6 R7 R9 R10
    cur = irq_in;
    for (int t = 0; t < 4000; t++) begin
      logic [7:0] a;
      bit we;
      if ($urandom_range(3) == 0) cur = cur ^ (16'h1 << $urandom_range(15));
      if ($urandom_range(15) == 0) cur = cur ^ 16'($urandom);
      we = ($urandom_range(2) == 0);
      a = alist[$urandom_range(15)];
      tick(cur, we, a, $urandom);
      check("R6 random host", {31'h0, host_irq}, {31'h0, m_host});
      rd("R5 random read", alist[$urandom_range(15)]);
    end
    rd("R5 final pend", 8'hD0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule